// File: doc/BRIEF.md
# Byte-Lane Bus Width Adapter

This block bridges a wide internal access port, 32 bits by default, to an external memory bus. A run-time input sets the external bus to 8 or 16 bits. Each internal access is word-aligned and carries a per-byte enable mask. The adapter breaks the access into as many one-clock external cycles as the narrow bus needs. It drives the external word address with the low address bits dropped to suit the bus width. It also raises per-lane byte selects and write strobes. Read bytes are gathered back into the internal word.

A second run-time input sets the byte order, little- or big-endian. In little-endian order, internal lane i holds the byte at offset i of the aligned block. In big-endian order, lane i holds the byte at offset N-1-i. External cycles whose bytes are all masked off are never issued. An access whose address is not aligned to the internal word width is refused with an error response, and no external cycle is started for it. Both configuration inputs are sampled when a request is accepted.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, and `ext_cyc`, `ext_rd`, `ext_wr_hi` and `ext_wr_lo` are all 0.
- R2: A request whose `req_addr` has any of its low log2(N) bits set gets a response one clock after acceptance with `rsp_err`=1 and `rsp_rdata`=0. No external cycle is issued for it.
- R3: In 8-bit mode (`cfg_bus16`=0), each external cycle moves one byte on `ext_wdata[15:8]`/`ext_rdata[15:8]` with `ext_addr` equal to the full byte address. `ext_wr_lo` and `ext_bsel[0]` stay 0.
- R4: In 16-bit mode, `ext_addr` is the byte address shifted right by one. The even byte travels on bits 15:8 with `ext_bsel[1]`/`ext_wr_hi`, and the odd byte travels on bits 7:0 with `ext_bsel[0]`/`ext_wr_lo`.
- R5: A fully enabled access takes N external cycles in 8-bit mode and N/2 in 16-bit mode. The cycles are issued one per clock, back to back, in ascending address order.
- R6: An external cycle is issued only if at least one of its bytes is enabled. An all-zero `req_be` produces no external cycle and a response one clock after acceptance.
- R7: A write strobe is raised only for an enabled byte, so bytes whose enable is 0 keep their old contents in memory.
- R8: `cfg_big_end`=0 maps internal lane i (bits 8i+7:8i, enabled by `req_be[i]`) to block offset i. `cfg_big_end`=1 maps it to offset N-1-i. The mapping applies to both reads and writes.
- R9: Read data returns the addressed bytes in the enabled lanes and 0 in the disabled lanes.
- R10: `rsp_valid` is a one-clock pulse, given exactly once per accepted request. `req_ready` is 0 from acceptance until the clock after that pulse.
- R11: `ext_rd` and the write strobes are raised only during `ext_cyc`, and a read strobe and a write strobe are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus16 | input | 1 | 1 selects the 16-bit external bus, 0 the 8-bit bus |
| cfg_big_end | input | 1 | 1 selects big-endian lane mapping |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Adapter idle, request accepted this clock |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address of the internal access |
| req_wdata | input | 8*N | Write data, lane i in bits 8i+7:8i |
| req_be | input | N | Per-lane byte enables |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Misaligned request refused |
| rsp_rdata | output | 8*N | Gathered read data |
| ext_cyc | output | 1 | External cycle active this clock |
| ext_addr | output | ADDR_W | External word address |
| ext_bsel | output | 2 | Byte selects, bit 1 upper lane, bit 0 lower lane |
| ext_rd | output | 1 | Read strobe |
| ext_wr_hi | output | 1 | Write strobe for bits 15:8 |
| ext_wr_lo | output | 1 | Write strobe for bits 7:0 |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data, sampled at the end of the cycle |

## Verification
The bench builds the adapter with N=4 byte lanes and a 10-bit address. This gives four-beat 8-bit transfers and two-beat 16-bit transfers, and lets a bench-side byte memory of 1 KiB hold every block that is touched. With these values, every pairing of bus width and byte order can be reached. So can sparse enable masks that skip whole beats, single-lane writes on the upper lane, and misaligned addresses at each low-bit offset. The small address space also lets the bench compare the whole written block against its own shadow copy after each write.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned EXT_W  = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_RESP = 2'd2
   } bwa_state_e;
endpackage

// File: rtl/bwa_beat_plan.sv
// Builds the mask of external beats that carry at least one enabled byte.
module bwa_beat_plan #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] be,
   input  logic         bus16,
   input  logic         big,
   output logic [N-1:0] pend
);
   localparam int unsigned HALF = N / 2;

   logic [N-1:0] narrow_le, narrow_be, wide_le, wide_be;

   for (genvar b = 0; b < N; b++) begin : g_narrow
      assign narrow_le[b] = be[b];
      assign narrow_be[b] = be[N-1-b];
   end

   for (genvar b = 0; b < N; b++) begin : g_wide
      if (b < HALF) begin : g_used
         assign wide_le[b] = be[2*b] | be[2*b+1];
         assign wide_be[b] = be[N-1-2*b] | be[N-2-2*b];
      end else begin : g_spare
         assign wide_le[b] = 1'b0;
         assign wide_be[b] = 1'b0;
      end
   end

   always_comb begin
      if (bus16) pend = big ? wide_be : wide_le;
      else       pend = big ? narrow_be : narrow_le;
   end
endmodule

// File: rtl/bwa_beat_pick.sv
// Chooses the lowest pending beat and the mask left after it.
module bwa_beat_pick #(
   parameter int unsigned N = 4,
   localparam int unsigned OFF_W = $clog2(N)
) (
   input  logic [N-1:0]     pend,
   output logic [OFF_W-1:0] beat,
   output logic             any,
   output logic [N-1:0]     pend_next
);
   always_comb begin
      beat = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) beat = OFF_W'(i);
      end
   end

   assign any       = |pend;
   assign pend_next = pend & (pend - 1'b1);
endmodule

// File: rtl/bwa_lane_route.sv
// Maps one external beat to its address, byte selects, lanes and write data.
module bwa_lane_route #(
   parameter int unsigned N      = 4,
   parameter int unsigned ADDR_W = 16,
   localparam int unsigned OFF_W = $clog2(N),
   localparam int unsigned BLK_W = ADDR_W - OFF_W
) (
   input  logic [BLK_W-1:0]  blk,
   input  logic [OFF_W-1:0]  beat,
   input  logic              bus16,
   input  logic              big,
   input  logic [N-1:0]      be,
   input  logic [8*N-1:0]    wdata,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        bsel,
   output logic [OFF_W-1:0]  lane_hi,
   output logic [OFF_W-1:0]  lane_lo,
   output logic [15:0]       wdata16
);
   function automatic logic [OFF_W-1:0] lane_of(input logic [OFF_W-1:0] off,
                                                input logic big_i);
      return big_i ? (OFF_W'(N - 1) - off) : off;
   endfunction

   logic [OFF_W-1:0] off_hi, off_lo;

   always_comb begin
      off_hi  = bus16 ? {beat[OFF_W-2:0], 1'b0} : beat;
      off_lo  = {beat[OFF_W-2:0], 1'b1};
      lane_hi = lane_of(off_hi, big);
      lane_lo = lane_of(off_lo, big);
      bsel[1] = be[lane_hi];
      bsel[0] = bus16 & be[lane_lo];
      wdata16[15:8] = wdata[{lane_hi, 3'b000} +: 8];
      wdata16[7:0]  = bus16 ? wdata[{lane_lo, 3'b000} +: 8] : 8'h00;
      if (bus16) addr = {1'b0, blk, beat[OFF_W-2:0]};
      else       addr = {blk, beat};
   end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
   import bwa_pkg::*;
#(
   parameter int unsigned N      = 4,
   parameter int unsigned ADDR_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_bus16,
   input  logic                cfg_big_end,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_we,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [8*N-1:0]      req_wdata,
   input  logic [N-1:0]        req_be,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [8*N-1:0]      rsp_rdata,
   output logic                ext_cyc,
   output logic [ADDR_W-1:0]   ext_addr,
   output logic [1:0]          ext_bsel,
   output logic                ext_rd,
   output logic                ext_wr_hi,
   output logic                ext_wr_lo,
   output logic [EXT_W-1:0]    ext_wdata,
   input  logic [EXT_W-1:0]    ext_rdata
);
   localparam int unsigned OFF_W = $clog2(N);
   localparam int unsigned BLK_W = ADDR_W - OFF_W;

   if (N < 4 || (N & (N - 1)) != 0) begin : g_bad_lanes
      $error("bus_width_adapter: N must be a power of two, at least 4");
   end
   if (ADDR_W <= OFF_W + 1) begin : g_bad_addr
      $error("bus_width_adapter: ADDR_W too small for N");
   end

   bwa_state_e       state_q;
   logic             we_q, bus16_q, big_q, err_q;
   logic [BLK_W-1:0] blk_q;
   logic [8*N-1:0]   wdata_q, rdata_q;
   logic [N-1:0]     be_q, pend_q;

   logic [N-1:0]     pend_init, pend_next;
   logic [OFF_W-1:0] beat, lane_hi, lane_lo;
   logic             pend_any, misaligned, accept;

   assign accept     = (state_q == ST_IDLE) && req_valid;
   assign misaligned = |req_addr[OFF_W-1:0];

   bwa_beat_plan #(.N(N)) plan_i (
      .be    (req_be),
      .bus16 (cfg_bus16),
      .big   (cfg_big_end),
      .pend  (pend_init)
   );

   bwa_beat_pick #(.N(N)) pick_i (
      .pend      (pend_q),
      .beat      (beat),
      .any       (pend_any),
      .pend_next (pend_next)
   );

   bwa_lane_route #(.N(N), .ADDR_W(ADDR_W)) route_i (
      .blk     (blk_q),
      .beat    (beat),
      .bus16   (bus16_q),
      .big     (big_q),
      .be      (be_q),
      .wdata   (wdata_q),
      .addr    (ext_addr),
      .bsel    (ext_bsel),
      .lane_hi (lane_hi),
      .lane_lo (lane_lo),
      .wdata16 (ext_wdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         bus16_q <= 1'b0;
         big_q   <= 1'b0;
         err_q   <= 1'b0;
         blk_q   <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         be_q    <= '0;
         pend_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  we_q    <= req_we;
                  bus16_q <= cfg_bus16;
                  big_q   <= cfg_big_end;
                  blk_q   <= req_addr[ADDR_W-1:OFF_W];
                  wdata_q <= req_wdata;
                  be_q    <= req_be;
                  rdata_q <= '0;
                  err_q   <= misaligned;
                  if (misaligned || pend_init == '0) begin
                     pend_q  <= '0;
                     state_q <= ST_RESP;
                  end else begin
                     pend_q  <= pend_init;
                     state_q <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               pend_q <= pend_next;
               if (!we_q) begin
                  for (int i = 0; i < N; i++) begin
                     if (ext_bsel[1] && lane_hi == OFF_W'(i))
                        rdata_q[8*i +: 8] <= ext_rdata[15:8];
                     if (ext_bsel[0] && lane_lo == OFF_W'(i))
                        rdata_q[8*i +: 8] <= ext_rdata[7:0];
                  end
               end
               if (pend_next == '0) state_q <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_err   = rsp_valid & err_q;
   assign rsp_rdata = rdata_q;
   assign ext_cyc   = (state_q == ST_RUN) & pend_any;
   assign ext_rd    = ext_cyc & ~we_q;
   assign ext_wr_hi = ext_cyc & we_q & ext_bsel[1];
   assign ext_wr_lo = ext_cyc & we_q & ext_bsel[0];

   AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst_n) |=> !ext_cyc && req_ready); // R1
   AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && misaligned) |=> (rsp_valid && rsp_err && !ext_cyc)); // R2
   AST_NARROW_LO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc && !bus16_q) |-> (!ext_wr_lo && !ext_bsel[0])); // R3
   AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc && $past(ext_cyc)) |-> (ext_addr > $past(ext_addr))); // R5
   AST_CYC_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_cyc |-> (ext_bsel != 2'b00)); // R6
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready)); // R10
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_cyc || rsp_valid) |-> !req_ready); // R10
   AST_STROBE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_cyc |-> (!ext_rd && !ext_wr_hi && !ext_wr_lo)); // R11
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_rd && (ext_wr_hi || ext_wr_lo))); // R11
endmodule

// File: tb/bus_width_adapter_tb_top.sv
module bus_width_adapter_tb_top;
   localparam int N  = 4;
   localparam int AW = 10;

   typedef struct packed {
      logic          we;
      logic          bus16;
      logic          big;
      logic [AW-1:0] addr;
      logic [31:0]   wdata;
      logic [3:0]    be;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b0, 10'h040, 32'hA1B2C3D4, 4'b1111},
      '{1'b0, 1'b0, 1'b0, 10'h040, 32'h0,        4'b1111},
      '{1'b0, 1'b1, 1'b1, 10'h040, 32'h0,        4'b1111},
      '{1'b1, 1'b1, 1'b1, 10'h080, 32'h11223344, 4'b1111},
      '{1'b0, 1'b0, 1'b1, 10'h080, 32'h0,        4'b1111},
      '{1'b1, 1'b0, 1'b0, 10'h0C0, 32'h55667788, 4'b0101},
      '{1'b0, 1'b1, 1'b0, 10'h0C0, 32'h0,        4'b0110},
      '{1'b1, 1'b1, 1'b0, 10'h100, 32'h99AABBCC, 4'b0011},
      '{1'b0, 1'b1, 1'b0, 10'h100, 32'h0,        4'b1100},
      '{1'b0, 1'b0, 1'b0, 10'h100, 32'h0,        4'b0000},
      '{1'b1, 1'b1, 1'b0, 10'h102, 32'hFFFFFFFF, 4'b1111},
      '{1'b0, 1'b0, 1'b1, 10'h101, 32'h0,        4'b1111},
      '{1'b1, 1'b1, 1'b1, 10'h140, 32'hDEADBEEF, 4'b1000},
      '{1'b0, 1'b0, 1'b1, 10'h140, 32'h0,        4'b1001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_bus16 = 1'b0, cfg_big_end = 1'b0;
   logic req_valid = 1'b0, req_we = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0] req_be = '0;
   logic rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;
   logic ext_cyc, ext_rd, ext_wr_hi, ext_wr_lo;
   logic [AW-1:0] ext_addr;
   logic [1:0] ext_bsel;
   logic [15:0] ext_wdata, ext_rdata;

   int errors = 0;
   int checks = 0;
   logic [7:0] mem    [1024];
   logic [7:0] shadow [1024];

   always #2.5 clk = ~clk;

   bus_width_adapter #(.N(N), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16), .cfg_big_end(cfg_big_end),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .ext_cyc(ext_cyc), .ext_addr(ext_addr), .ext_bsel(ext_bsel), .ext_rd(ext_rd),
      .ext_wr_hi(ext_wr_hi), .ext_wr_lo(ext_wr_lo), .ext_wdata(ext_wdata),
      .ext_rdata(ext_rdata)
   );

   // External memory model: 16-bit mode puts the even byte on bits 15:8.
   always_comb begin
      if (cfg_bus16) ext_rdata = {mem[{ext_addr[8:0], 1'b0}], mem[{ext_addr[8:0], 1'b1}]};
      else           ext_rdata = {mem[ext_addr], 8'h00};
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= 8'(i * 7 + 3);
      end else begin
         if (ext_wr_hi) begin
            if (cfg_bus16) mem[{ext_addr[8:0], 1'b0}] <= ext_wdata[15:8];
            else           mem[ext_addr] <= ext_wdata[15:8];
         end
         if (ext_wr_lo) mem[{ext_addr[8:0], 1'b1}] <= ext_wdata[7:0];
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int off_of(input int lane, input logic big);
      return big ? (N - 1 - lane) : lane;
   endfunction

   task automatic run_vec(input vec_t v);
      int exp_cyc, got_cyc;
      bit addr_ok, strobe_ok, busy_ok, exp_err;
      logic [31:0] exp_rd;
      logic [31:0] got_rd;
      logic got_err;
      exp_err = (v.addr[1:0] != 2'b00);
      exp_cyc = 0;
      if (!exp_err) begin
         if (!v.bus16) begin
            for (int i = 0; i < N; i++) exp_cyc += int'(v.be[i]);
         end else begin
            for (int p = 0; p < N / 2; p++) begin
               bit hit;
               hit = 1'b0;
               for (int i = 0; i < N; i++)
                  if (v.be[i] && (off_of(i, v.big) / 2 == p)) hit = 1'b1;
               exp_cyc += int'(hit);
            end
         end
      end
      exp_rd = '0;
      if (!exp_err && !v.we)
         for (int i = 0; i < N; i++)
            if (v.be[i]) exp_rd[8*i +: 8] = shadow[v.addr + AW'(off_of(i, v.big))];

      @(negedge clk);
      cfg_bus16 = v.bus16; cfg_big_end = v.big;
      req_we = v.we; req_addr = v.addr; req_wdata = v.wdata; req_be = v.be;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      got_cyc = 0; addr_ok = 1'b1; strobe_ok = 1'b1; busy_ok = 1'b1;
      for (int g = 0; g < 24; g++) begin
         if (req_ready) busy_ok = 1'b0;
         if (ext_cyc) begin
            got_cyc++;
            if (v.bus16) begin
               if (ext_addr[9] !== 1'b0 || ext_addr[8:1] !== v.addr[9:2]) addr_ok = 1'b0;
            end else begin
               if (ext_addr[9:2] !== v.addr[9:2]) addr_ok = 1'b0;
               if (ext_wr_lo || ext_bsel[0]) strobe_ok = 1'b0;
            end
         end
         if ((ext_rd && (ext_wr_hi || ext_wr_lo)) || (!ext_cyc && (ext_rd || ext_wr_hi || ext_wr_lo)))
            strobe_ok = 1'b0;
         if (rsp_valid) break;
         @(negedge clk);
      end
      got_err = rsp_err;
      got_rd  = rsp_rdata;
      check(rsp_valid === 1'b1, "R10 response pulse present", 32'(rsp_valid), 32'd1);
      check(got_err === exp_err, "R2 error flag", 32'(got_err), 32'(exp_err));
      check(got_cyc == exp_cyc, "R5/R6 external cycle count", 32'(got_cyc), 32'(exp_cyc));
      check(busy_ok, "R10 ready low while busy", 32'(busy_ok), 32'd1);
      check(strobe_ok, "R3/R11 strobe usage", 32'(strobe_ok), 32'd1);
      if (v.bus16) check(addr_ok, "R4 word address in 16-bit mode", 32'(addr_ok), 32'd1);
      else         check(addr_ok, "R3 byte address in 8-bit mode", 32'(addr_ok), 32'd1);
      if (!v.we || exp_err)
         check(got_rd === exp_rd, "R8/R9 read data", got_rd, exp_rd);
      @(negedge clk);
      check(rsp_valid === 1'b0 && req_ready === 1'b1, "R10 single pulse then ready",
            {30'd0, rsp_valid, req_ready}, 32'd1);
      if (v.we && !exp_err) begin
         bit same;
         for (int i = 0; i < N; i++)
            if (v.be[i]) shadow[v.addr + AW'(off_of(i, v.big))] = v.wdata[8*i +: 8];
         same = 1'b1;
         for (int k = 0; k < N; k++) if (mem[v.addr + AW'(k)] !== shadow[v.addr + AW'(k)]) same = 1'b0;
         check(same, "R7/R8 written block contents", {mem[v.addr], mem[v.addr + 1],
               mem[v.addr + 2], mem[v.addr + 3]}, {shadow[v.addr], shadow[v.addr + 1],
               shadow[v.addr + 2], shadow[v.addr + 3]});
      end
   endtask

   bit done = 1'b0;

   initial begin
      for (int i = 0; i < 1024; i++) shadow[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready === 1'b1 && rsp_valid === 1'b0 && ext_cyc === 1'b0 &&
            ext_rd === 1'b0 && ext_wr_hi === 1'b0 && ext_wr_lo === 1'b0,
            "R1 reset state", {26'd0, req_ready, rsp_valid, ext_cyc, ext_rd, ext_wr_hi, ext_wr_lo},
            32'h20);
      rst_n = 1'b1;
      @(negedge clk);
      for (int n = 0; n < NV; n++) run_vec(VECS[n]);
      // Corner: all-zero mask in 16-bit big-endian mode, R6
      run_vec('{1'b1, 1'b1, 1'b1, 10'h180, 32'hCAFEF00D, 4'b0000});
      // Corner: each misaligned offset, R2
      for (int o = 1; o < 4; o++)
         run_vec('{1'b0, 1'b1, 1'b0, 10'h1C0 + AW'(o), 32'h0, 4'b1111});
      // Corner: single low lane write on 16-bit bus lands on the odd lane, R4
      run_vec('{1'b1, 1'b1, 1'b1, 10'h200, 32'h000000A5, 4'b0001});
      run_vec('{1'b0, 1'b1, 1'b1, 10'h200, 32'h0, 4'b1111});
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule